// File: doc/BRIEF.md
# Multiplierless Second-Order Recursive Filter Section

This block is one second-order recursive filter section. For each accepted input sample it forms y[n] = x[n] + c1·y[n-1] + c2·y[n-2]. The two coefficients are fixed when the design is elaborated. No hardware multiplier is used. Each coefficient is a short list of signed power-of-two digits, so every product is a set of shifted copies of a stored output, each added or inverted. The input sample, a rounding-correction constant and all shifted terms are combined by a chain of 3:2 carry-save stages. A single carry-propagate adder at the root then resolves the total.

A saturating quantizer sits inside the recursion. It drops the fractional bits by rounding toward negative infinity and clamps the result to the data word length. The quantized value is stored as the new y[n-1], and the old y[n-1] moves to y[n-2]. The stored value is also the output, one clock after the sample was accepted. Cycles without an input strobe leave the filter state untouched.

Top module: `iir_sos_csa`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears both stored outputs to zero and drives `out_valid` low, so `out_data` reads 0 after reset.
- R2: With the default coefficients c1 = +1 - 2^-2 = 0.75 and c2 = -2^-1 + 2^-4 = -0.4375 (14 fractional bits), each output equals sat(floor(x[n] + 0.75·y[n-1] - 0.4375·y[n-2])). Here y[n-1] and y[n-2] are the two previously produced outputs.
- R3: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high, and `out_data` in that cycle is the filter result for that sample.
- R4: In a cycle with `in_valid` low, `out_valid` goes low in the next cycle, and the stored state, including `out_data`, keeps its value.
- R5: A result above 2^(W-1)-1 (32767 for W=16) is replaced by 32767.
- R6: A result below -2^(W-1) (-32768 for W=16) is replaced by -32768.
- R7: An in-range result with a fractional part is rounded toward negative infinity. For example, after the inputs 1, 0, 0 from reset, the outputs are 1, 0, -1.
- R8: The feedback uses the saturated value, not the unclamped sum. On the cycle after an accepted sample, the value that was in the y[n-1] register has moved into the y[n-2] register.
- R9: Every carry-save stage preserves the sum of its three operands modulo the accumulator width, with its carry vector weighted one bit position higher than its sum vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_data | input | W | Signed input sample |
| out_valid | output | 1 | Output strobe, one cycle after `in_valid` |
| out_data | output | W | Signed filtered output (the y[n-1] register) |

## Verification
The filter output is also its state. A wrong digit, shift or carry alignment in the carry-save chain therefore shows at `out_data` on the very next strobe. Because the error is fed back, it then keeps spreading into every later output instead of fading after one sample. A fault in the y[n-2] shift or in the quantizer shows on the next sample, or on the sample after that. It shows most strongly during long saturating runs and alternating extremes, where the clamped value, not the raw sum, decides every following result. The sweep compares each strobed output with an exact integer model, so any such divergence is caught at the first sample it affects.

// File: rtl/iir_sos_csa.sv
module iir_sos_csa #(
  parameter int W    = 16,
  parameter int FRAC = 14,
  parameter int NT   = 2,
  parameter logic [NT-1:0]   C1_ON  = 2'b11,
  parameter logic [NT-1:0]   C1_NEG = 2'b10,
  parameter logic [8*NT-1:0] C1_SH  = {8'd2, 8'd0},
  parameter logic [NT-1:0]   C2_ON  = 2'b11,
  parameter logic [NT-1:0]   C2_NEG = 2'b01,
  parameter logic [8*NT-1:0] C2_SH  = {8'd4, 8'd1}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  output logic [W-1:0] out_data
);

  function automatic int count_neg(logic [NT-1:0] on, logic [NT-1:0] ng);
    int n;
    n = 0;
    for (int i = 0; i < NT; i++) if (on[i] && ng[i]) n++;
    return n;
  endfunction

  localparam int G    = $clog2(2*NT + 2) + 2;
  localparam int AW   = W + FRAC + G;
  localparam int NOP  = 2 + 2*NT;
  localparam int NST  = NOP - 2;
  localparam int NEGS = count_neg(C1_ON, C1_NEG) + count_neg(C2_ON, C2_NEG);

  logic [W-1:0]  y1, y2;
  logic          vld;
  logic [AW-1:0] y1e, y2e;
  logic [AW-1:0] opd [NOP];
  logic [AW-1:0] sa [NST];
  logic [AW-1:0] sb [NST];
  logic [AW-1:0] sc [NST];
  logic [AW-1:0] sv [NST];
  logic [AW-1:0] cv [NST];
  logic [AW-1:0] res, q;
  logic          sat_hi, sat_lo;
  logic [W-1:0]  ynew;

  assign y1e    = {{(AW-W){y1[W-1]}}, y1};
  assign y2e    = {{(AW-W){y2[W-1]}}, y2};
  assign opd[0] = {{(AW-W-FRAC){in_data[W-1]}}, in_data, {FRAC{1'b0}}};
  assign opd[1] = AW'(NEGS);

  for (genvar i = 0; i < NT; i++) begin : g_terms
    localparam int S1 = int'(C1_SH[8*i +: 8]);
    localparam int S2 = int'(C2_SH[8*i +: 8]);
    if (!C1_ON[i])       begin : g_c1z assign opd[2+i] = '0; end
    else if (C1_NEG[i])  begin : g_c1n assign opd[2+i] = ~(y1e << (FRAC - S1)); end
    else                 begin : g_c1p assign opd[2+i] = y1e << (FRAC - S1); end
    if (!C2_ON[i])       begin : g_c2z assign opd[2+NT+i] = '0; end
    else if (C2_NEG[i])  begin : g_c2n assign opd[2+NT+i] = ~(y2e << (FRAC - S2)); end
    else                 begin : g_c2p assign opd[2+NT+i] = y2e << (FRAC - S2); end
  end

  for (genvar k = 0; k < NST; k++) begin : g_csa
    if (k == 0) begin : g_first
      assign sa[k] = opd[0];
      assign sb[k] = opd[1];
    end else begin : g_next
      assign sa[k] = sv[k-1];
      assign sb[k] = cv[k-1] << 1;
    end
    assign sc[k] = opd[k+2];
    assign sv[k] = sa[k] ^ sb[k] ^ sc[k];
    assign cv[k] = (sa[k] & sb[k]) | (sa[k] & sc[k]) | (sb[k] & sc[k]);

    assert_csa_sum_R9: assert property (@(posedge clk) disable iff (rst)
      sv[k] + (cv[k] << 1) == sa[k] + sb[k] + sc[k]);
  end

  assign res    = sv[NST-1] + (cv[NST-1] << 1);
  assign q      = AW'($signed(res) >>> FRAC);
  assign sat_hi = !q[AW-1] &&  (|q[AW-2:W-1]);
  assign sat_lo =  q[AW-1] && !(&q[AW-2:W-1]);
  assign ynew   = sat_hi ? {1'b0, {(W-1){1'b1}}} :
                  sat_lo ? {1'b1, {(W-1){1'b0}}} : q[W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      y1  <= '0;
      y2  <= '0;
      vld <= 1'b0;
    end else begin
      vld <= in_valid;
      if (in_valid) begin
        y1 <= ynew;
        y2 <= y1;
      end
    end
  end

  assign out_valid = vld;
  assign out_data  = y1;

  assert_reset_clears_R1: assert property (@(posedge clk)
    $past(rst) |-> (y1 == '0 && y2 == '0 && !out_valid));
  assert_valid_latency_R3: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(out_data) && $stable(y2)));
  assert_sat_high_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_hi) |=> out_data == {1'b0, {(W-1){1'b1}}});
  assert_sat_low_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && sat_lo) |=> out_data == {1'b1, {(W-1){1'b0}}});
  assert_floor_R7: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !sat_hi && !sat_lo) |=> out_data == $past(res[FRAC+W-1:FRAC]));
  assert_delay_line_R8: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> y2 == $past(out_data));

endmodule

// File: tb/test_iir_sos_csa.sv
module test_iir_sos_csa;
  localparam int W = 16;
  localparam longint MAXV = 32767;
  localparam longint MINV = -32768;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [W-1:0] in_data = '0;
  logic out_valid;
  logic [W-1:0] out_data;

  int checks = 0;
  int fails  = 0;
  longint y1m = 0, y2m = 0;

  always #2.5 clk = ~clk;

  iir_sos_csa i_iir_sos_csa (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic longint model(input longint x);
    longint v, r;
    v = x * 16384 + 12288 * y1m - 7168 * y2m;
    r = v >>> 14;
    if (r > MAXV) r = MAXV;
    if (r < MINV) r = MINV;
    y2m = y1m;
    y1m = r;
    return r;
  endfunction

  task automatic do_reset();
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    y1m = 0; y2m = 0;
    check(out_valid == 1'b0, "R1 valid", longint'(out_valid), 0);
    check(out_data == '0, "R1 data", longint'($signed(out_data)), 0);
  endtask

  task automatic send(input longint x, input string tag);
    longint e;
    string t;
    in_valid = 1'b1;
    in_data  = W'(x);
    e = model(x);
    @(negedge clk);
    t = (e == MAXV) ? "R5" : (e == MINV) ? "R6" : tag;
    check(out_valid == 1'b1, "R3 valid", longint'(out_valid), 1);
    check(longint'($signed(out_data)) == e, t, longint'($signed(out_data)), e);
  endtask

  task automatic idle(input int n);
    logic [W-1:0] held;
    held = out_data;
    in_valid = 1'b0;
    in_data  = 16'h5a5a;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R4 valid", longint'(out_valid), 0);
      check(out_data == held, "R4 hold", longint'($signed(out_data)), longint'($signed(held)));
    end
  endtask

  initial begin
    @(negedge clk);
    do_reset();
    send(1, "R7"); send(0, "R7"); send(0, "R7");
    idle(2);
    do_reset();
    send(1000, "R2 impulse");
    for (int i = 0; i < 25; i++) send(0, "R2 impulse");
    idle(3);
    for (int i = 0; i < 40; i++) send(5000, "R2 step");
    for (int i = 0; i < 40; i++) send(-3001, "R7 step");
    for (int x = -32768; x <= 32767; x += 97) begin
      send(longint'(x), "R2 sweep");
      if ((x & 63) == 0) idle(1);
    end
    for (int i = 0; i < 30; i++) send(MAXV, "R5");
    for (int i = 0; i < 30; i++) send(MINV, "R6");
    for (int i = 0; i < 40; i++) send((i % 2) ? MAXV : MINV, "R8");
    for (int i = 0; i < 3; i++) send(0, "R8");
    idle(2);
    do_reset();
    for (int i = 0; i < 2000; i++) begin
      send(longint'($signed(W'($urandom))), "R2 random");
      if (($urandom % 16) == 0) idle(1);
    end
    idle(2);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule